// File: doc/BRIEF.md
# Reloadable 16-bit Up-Counter with Prescaler and Event Input

This block is the time base of a modular timer system. A 16-bit up-counter advances on one of three sources: ticks from an internal 8-bit reloadable prescaler that divides a global prescaler tick, rising edges of an external event input, or falling edges of that input. A fourth source code stops the counter. The live count is driven without pause onto a counter bus that neighbouring timing blocks read.

When the counter steps past 0xFFFF it reloads from a modulus register and raises a sticky flag that serves as an interrupt request. A modulus of zero makes the counter free-running. Software can arm an event count by presetting the counter to the two's complement of N, which raises the flag after exactly N events. A separate external load input, with independently enabled rising and falling edges, copies the modulus into the counter at any time. Both external inputs pass through a two-flop synchronizer before edge detection on the system clock.

Software reaches the block through a small synchronous register port with a combinational read path: word 0 is control and status, word 1 is the counter and word 2 is the modulus.

Top module: `modcnt_timer`

## Requirements
- R1: After reset the counter, the modulus, the control word and the flag are all zero, and `cnt_bus` and `ovf_irq` are low.
- R2: Register port: address 0 holds the prescale value in bits [7:0], the source select in bits [9:8] (0 prescaler, 1 event rising edge, 2 event falling edge, 3 stopped), load-on-rising enable in bit 10, load-on-falling enable in bit 11, and reads the flag in bit 15 with bits [14:12] reading zero. Address 1 reads and presets the counter, address 2 reads and writes the modulus, and address 3 reads zero.
- R3: `cnt_bus` always equals the counter value that reads back at address 1.
- R4: With source 0 and prescale value P, the counter advances once every 256-P global ticks (0xFF divides by 1, 0x00 by 256). The prescaler reloads P whenever the source is switched to 0, and a tick that completes a prescaler period moves the counter on the same clock edge.
- R5: With source 1 or 2 the counter advances once per rising or falling event edge, three clock edges after the input changes. Source 3 holds the counter still.
- R6: An increment at 0xFFFF loads the modulus into the counter and sets the flag. With a modulus of 0 the counter wraps to 0.
- R7: A counter preset to the two's complement of N leaves the flag clear after N-1 events and sets it on the Nth.
- R8: An enabled edge of the synchronized load input copies the modulus into the counter three clock edges after the input changes. An edge whose enable bit is 0 leaves the counter unchanged.
- R9: A load and an increment in the same cycle leave the modulus in the counter, and a load never sets the flag.
- R10: The flag stays set until a write to address 0 with bit 15 at 0 follows a read of address 0 that saw the flag set. A write of 0 without that read, or a write of 1, leaves it set, and any write to address 0 cancels the armed clear.
- R11: An overflow in the same cycle as a valid clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gtick | input | 1 | Global prescaler tick, one cycle per tick |
| evt_in | input | 1 | External event input (asynchronous) |
| ld_in | input | 1 | External modulus load input (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cnt_bus | output | 16 | Live counter value |
| ovf_irq | output | 1 | Sticky overflow flag / interrupt request |

## Verification
Register writes and prescaler ticks change the counter and flag on the first clock edge, so the bench drives them half a cycle before an edge and samples at the next falling edge. Event and load inputs take three edges: two synchronizer stages and the edge-detect register. The bench checks that the counter is still unchanged after two edges and has moved after the third, and it holds each input level for four cycles before sampling. Prescale values are swept, and the expected count is the floor of the tick count divided by 256-P.

// File: rtl/modcnt_timer.sv
module modcnt_timer #(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gtick,
  input  logic             evt_in,
  input  logic             ld_in,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] cnt_bus,
  output logic             ovf_irq
);
  localparam int SEL_LO   = PRE_W;
  localparam int LR_BIT   = PRE_W + 2;
  localparam int LF_BIT   = PRE_W + 3;
  localparam int FLAG_BIT = CNT_W - 1;

  logic [PRE_W-1:0]     pre_val, pre_cnt;
  logic [1:0]           src;
  logic                 ld_re_en, ld_fe_en, flag_q, clr_arm;
  logic [CNT_W-1:0]     cnt_q, mod_q;
  logic [SYNC_STAGES:0] evt_sh, ld_sh;

  wire wr_ctrl = reg_wr && reg_addr == 2'd0;
  wire wr_cnt  = reg_wr && reg_addr == 2'd1;
  wire wr_mod  = reg_wr && reg_addr == 2'd2;

  wire evt_rise = evt_sh[SYNC_STAGES-1] & ~evt_sh[SYNC_STAGES];
  wire evt_fall = ~evt_sh[SYNC_STAGES-1] & evt_sh[SYNC_STAGES];
  wire ld_rise  = ld_sh[SYNC_STAGES-1] & ~ld_sh[SYNC_STAGES];
  wire ld_fall  = ~ld_sh[SYNC_STAGES-1] & ld_sh[SYNC_STAGES];

  wire pre_tick  = gtick && (pre_cnt == '1);
  wire enter_pre = wr_ctrl && (reg_wdata[SEL_LO +: 2] == 2'd0) && (src != 2'd0);
  wire ld_fire   = (ld_re_en & ld_rise) | (ld_fe_en & ld_fall);
  wire at_max    = (cnt_q == '1);

  logic inc;
  always_comb begin
    case (src)
      2'd0:    inc = pre_tick;
      2'd1:    inc = evt_rise;
      2'd2:    inc = evt_fall;
      default: inc = 1'b0;
    endcase
  end

  wire ovf      = inc && at_max && !ld_fire && !wr_cnt;
  wire clr_hit  = wr_ctrl && clr_arm && !reg_wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_sh <= '0;
      ld_sh  <= '0;
    end else begin
      evt_sh <= {evt_sh[SYNC_STAGES-1:0], evt_in};
      ld_sh  <= {ld_sh[SYNC_STAGES-1:0], ld_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_val  <= '0;
      src      <= 2'd0;
      ld_re_en <= 1'b0;
      ld_fe_en <= 1'b0;
      mod_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        pre_val  <= reg_wdata[PRE_W-1:0];
        src      <= reg_wdata[SEL_LO +: 2];
        ld_re_en <= reg_wdata[LR_BIT];
        ld_fe_en <= reg_wdata[LF_BIT];
      end
      if (wr_mod) mod_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_cnt <= '0;
    else if (enter_pre) pre_cnt <= reg_wdata[PRE_W-1:0];
    else if (pre_tick)  pre_cnt <= pre_val;
    else if (gtick)     pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= reg_wdata;
    else if (ld_fire) cnt_q <= mod_q;
    else if (inc)     cnt_q <= at_max ? mod_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      clr_arm <= 1'b0;
    end else begin
      if (ovf)          flag_q <= 1'b1;
      else if (clr_hit) flag_q <= 1'b0;
      if (wr_ctrl)                                     clr_arm <= 1'b0;
      else if (reg_rd && reg_addr == 2'd0 && flag_q)   clr_arm <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[PRE_W-1:0]     = pre_val;
        reg_rdata[SEL_LO +: 2]   = src;
        reg_rdata[LR_BIT]        = ld_re_en;
        reg_rdata[LF_BIT]        = ld_fe_en;
        reg_rdata[FLAG_BIT]      = flag_q;
      end
      2'd1:    reg_rdata = cnt_q;
      2'd2:    reg_rdata = mod_q;
      default: reg_rdata = '0;
    endcase
  end

  assign cnt_bus = cnt_q;
  assign ovf_irq = flag_q;

  a_r4_prescaler_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (gtick && !enter_pre && pre_cnt != '1) |=> pre_cnt == PRE_W'($past(pre_cnt) + 1'b1));

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd3 && !wr_cnt && !ld_fire) |=> $stable(cnt_q));

  a_r6_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && at_max && !ld_fire && !wr_cnt) |=> (cnt_q == $past(mod_q)) && flag_q);

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !wr_cnt) |=> cnt_q == $past(mod_q));

  a_r9_load_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !flag_q) |=> !flag_q);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_ctrl) |=> flag_q);

  a_r11_clear_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && inc && at_max && !ld_fire && !wr_cnt) |=> flag_q);

endmodule

// File: tb/modcnt_timer_tb.sv
module modcnt_timer_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, gtick, evt_in, ld_in, reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, cnt_bus;
  logic        ovf_irq;
  logic [15:0] tmp;
  int checks = 0, fails = 0;

  modcnt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .gtick(gtick), .evt_in(evt_in), .ld_in(ld_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_bus(cnt_bus), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clr_flag();
    logic [15:0] c;
    rd(2'd0, c);
    wr(2'd0, c & 16'h7FFF);
  endtask

  task automatic evt_pulse();
    evt_in = 1'b1; repeat (4) @(negedge clk);
    evt_in = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic gpulse();
    gtick = 1'b1; @(negedge clk); gtick = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] plist [6] = '{8'hFF, 8'hFE, 8'hFD, 8'hF0, 8'hC0, 8'h00};
    int nlist [5] = '{1, 2, 3, 5, 17};
    rst_n = 1'b0; gtick = 0; evt_in = 0; ld_in = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 cnt_bus", cnt_bus, 0);
    chk("R1 ovf_irq", ovf_irq, 0);
    rd(2'd0, tmp); chk("R1 ctrl", tmp, 0);
    rd(2'd1, tmp); chk("R1 counter", tmp, 0);
    rd(2'd2, tmp); chk("R1 modulus", tmp, 0);

    wr(2'd0, 16'h7E5A); rd(2'd0, tmp); chk("R2 ctrl readback", tmp, 16'h0E5A);
    wr(2'd2, 16'hBEEF); rd(2'd2, tmp); chk("R2 modulus readback", tmp, 16'hBEEF);
    wr(2'd1, 16'h1357); rd(2'd1, tmp); chk("R2 counter readback", tmp, 16'h1357);
    chk("R3 bus equals counter", cnt_bus, 16'h1357);
    rd(2'd3, tmp); chk("R2 addr3 zero", tmp, 0);

    for (int i = 0; i < 6; i++) begin
      wr(2'd0, 16'h0300 | plist[i]);
      wr(2'd1, 16'h0000);
      wr(2'd0, {8'h00, plist[i]});
      gtick = 1'b1; repeat (600) @(negedge clk); gtick = 1'b0;
      chk($sformatf("R4 divide P=%02h", plist[i]), cnt_bus, 600 / (256 - plist[i]));
    end
    wr(2'd0, 16'h03FC); wr(2'd1, 0); wr(2'd0, 16'h00FC);
    for (int i = 0; i < 40; i++) begin gpulse(); @(negedge clk); end
    chk("R4 sparse ticks div4", cnt_bus, 10);
    wr(2'd0, 16'h03FF); wr(2'd1, 16'h0020); wr(2'd0, 16'h00FF);
    gpulse();
    chk("R4 same-edge step", cnt_bus, 16'h0021);

    wr(2'd0, 16'h0300); wr(2'd1, 0); wr(2'd0, 16'h0100);
    evt_in = 1'b1;
    repeat (2) @(negedge clk); chk("R5 not before third edge", cnt_bus, 0);
    @(negedge clk);           chk("R5 third edge count", cnt_bus, 1);
    evt_in = 1'b0; repeat (4) @(negedge clk);
    chk("R5 rising ignores fall", cnt_bus, 1);
    for (int i = 0; i < 7; i++) evt_pulse();
    chk("R5 rising count", cnt_bus, 8);
    rd(2'd1, tmp); chk("R3 bus matches read", tmp, cnt_bus);
    wr(2'd1, 0); wr(2'd0, 16'h0200);
    evt_in = 1'b1; repeat (4) @(negedge clk);
    chk("R5 falling ignores rise", cnt_bus, 0);
    evt_in = 1'b0; repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) evt_pulse();
    chk("R5 falling count", cnt_bus, 5);
    wr(2'd0, 16'h0300);
    for (int i = 0; i < 3; i++) evt_pulse();
    chk("R5 stopped", cnt_bus, 5);

    wr(2'd2, 16'h1234); wr(2'd1, 16'hFFFE); wr(2'd0, 16'h0100);
    evt_pulse(); chk("R6 reach max", cnt_bus, 16'hFFFF); chk("R6 no flag yet", ovf_irq, 0);
    evt_pulse(); chk("R6 reload modulus", cnt_bus, 16'h1234); chk("R6 flag set", ovf_irq, 1);
    clr_flag(); chk("R10 cleared", ovf_irq, 0);
    wr(2'd2, 0); wr(2'd1, 16'hFFFF);
    evt_pulse(); chk("R6 free-run wrap", cnt_bus, 0); chk("R6 free-run flag", ovf_irq, 1);
    clr_flag();

    for (int k = 0; k < 5; k++) begin
      wr(2'd1, 16'(-nlist[k]));
      for (int i = 0; i < nlist[k] - 1; i++) evt_pulse();
      chk($sformatf("R7 N=%0d before last", nlist[k]), ovf_irq, 0);
      evt_pulse();
      chk($sformatf("R7 N=%0d flag", nlist[k]), ovf_irq, 1);
      chk($sformatf("R7 N=%0d count", nlist[k]), cnt_bus, 0);
      clr_flag();
    end

    wr(2'd1, 16'hFFFF); evt_pulse(); chk("R10 set", ovf_irq, 1);
    wr(2'd0, 16'h0100); chk("R10 write without read", ovf_irq, 1);
    rd(2'd0, tmp); chk("R2 flag bit reads", tmp, 16'h8100);
    wr(2'd0, 16'h8100); chk("R10 write one", ovf_irq, 1);
    wr(2'd0, 16'h0100); chk("R10 disarmed by write", ovf_irq, 1);
    rd(2'd0, tmp); wr(2'd0, 16'h0100); chk("R10 valid clear", ovf_irq, 0);

    wr(2'd0, 16'h03FF); wr(2'd0, 16'h00FF); wr(2'd2, 16'h0077); wr(2'd1, 16'hFFFF);
    gpulse(); chk("R11 setup flag", ovf_irq, 1); chk("R11 setup reload", cnt_bus, 16'h0077);
    wr(2'd1, 16'hFFFF); rd(2'd0, tmp);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h00FF; gtick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; gtick = 1'b0;
    chk("R11 flag kept", ovf_irq, 1); chk("R11 reload", cnt_bus, 16'h0077);
    clr_flag(); chk("R11 cleared after", ovf_irq, 0);

    wr(2'd0, 16'h0300); wr(2'd2, 16'hABCD); wr(2'd1, 16'h0005);
    ld_in = 1'b1; repeat (4) @(negedge clk); ld_in = 1'b0; repeat (4) @(negedge clk);
    chk("R8 disabled edges", cnt_bus, 16'h0005);
    wr(2'd0, 16'h0700);
    ld_in = 1'b1; repeat (2) @(negedge clk); chk("R8 not before third edge", cnt_bus, 16'h0005);
    @(negedge clk); chk("R8 rising load", cnt_bus, 16'hABCD);
    wr(2'd1, 16'h0005); ld_in = 1'b0; repeat (4) @(negedge clk);
    chk("R8 fall disabled", cnt_bus, 16'h0005);
    wr(2'd0, 16'h0B00);
    ld_in = 1'b1; repeat (4) @(negedge clk); chk("R8 rise disabled", cnt_bus, 16'h0005);
    ld_in = 1'b0; repeat (4) @(negedge clk); chk("R8 falling load", cnt_bus, 16'hABCD);
    wr(2'd0, 16'h0F00); wr(2'd1, 16'h0005);
    ld_in = 1'b1; repeat (4) @(negedge clk); chk("R8 both rise", cnt_bus, 16'hABCD);
    wr(2'd1, 16'h0005);
    ld_in = 1'b0; repeat (4) @(negedge clk); chk("R8 both fall", cnt_bus, 16'hABCD);
    chk("R9 loads leave flag", ovf_irq, 0);

    wr(2'd0, 16'h0500); wr(2'd2, 16'h0042); wr(2'd1, 16'h0010);
    evt_in = 1'b1; ld_in = 1'b1; repeat (4) @(negedge clk);
    chk("R9 load beats increment", cnt_bus, 16'h0042);
    wr(2'd1, 16'hFFFF);
    evt_in = 1'b0; ld_in = 1'b0; repeat (4) @(negedge clk);
    chk("R9 idle falls", cnt_bus, 16'hFFFF);
    evt_in = 1'b1; ld_in = 1'b1; repeat (4) @(negedge clk);
    chk("R9 load at max", cnt_bus, 16'h0042);
    chk("R9 no overflow flag", ovf_irq, 0);

    finish_run();
  end
endmodule